// File: doc/BRIEF.md
# Opcode-Fetch Program/Data Space Separator

This block watches the bus of an 8-bit microprocessor and drives one extra high address bit, `prog_space`. That bit sends each memory read either to program memory or to a separate 64K data memory. The processor marks only opcode bytes with its fetch status strobe. Immediate operands and index displacements arrive as ordinary reads. For this reason the block decodes the structure of every instruction: prefixes, displacement bytes and immediate bytes. It then keeps every byte of the instruction stream in program space, and it sends all other reads, and all writes, to data space.

Each bus phase lasts several clocks. The block samples the strobes on every clock and latches the byte on the read data bus while the read is active. It decodes that byte on the clock after the read strobe goes inactive. A second, independent function serves slow program memory. When `slow_prog` is high, the block requests exactly one wait clock at the start of every opcode fetch. Plain data reads never get a wait clock.

The tracker is a state machine with six states:

- `TRK_IDLE`: expects a new opcode.
- `TRK_INDEX`: an index prefix has been seen.
- `TRK_BITOP`: a plain bit-operation prefix has been seen.
- `TRK_OPERAND`: counts the remaining operand bytes.
- `TRK_XDISP`: waits for the displacement byte of an indexed bit operation.
- `TRK_XOP`: waits for the final opcode byte of an indexed bit operation.

Its transitions are:

- **prefix-in**: from `TRK_IDLE` or `TRK_INDEX` to `TRK_INDEX` on an index prefix.
- **bit-in**: from `TRK_IDLE` to `TRK_BITOP`.
- **xbit-in**: from `TRK_INDEX` to `TRK_XDISP` on the bit prefix.
- **operand-load**: to `TRK_OPERAND` on an opcode that has operand bytes.
- **operand-step**: decrement the count.
- **operand-done**: from `TRK_OPERAND` to `TRK_IDLE`.
- **disp-done**: from `TRK_XDISP` to `TRK_XOP`.
- **final-op**: from `TRK_BITOP` or `TRK_XOP` to `TRK_IDLE`.
- **resync**: an opcode fetch in `TRK_OPERAND` or `TRK_XDISP` is decoded as a new opcode.

Top module: `opsep_top`

## Requirements
- R1: After reset the tracker is in `TRK_IDLE`. A non-fetch read then gives `prog_space`=0, and `wait_req` is 0.
- R2: During every read with `opfetch`=1, `prog_space` is 1 on every clock of the read. When no memory read is active, `prog_space` is 0.
- R3: Opcodes with bits [7:6] equal to 00 or 11 and bits [2:0] equal to 110 have one operand byte. The next non-fetch read goes to program space, and the read after it goes to data space.
- R4: Opcodes 0x01, 0x11, 0x21, 0x31, 0xC3 and 0xCD have two operand bytes. The next two non-fetch reads go to program space.
- R5: All other opcodes have no operand byte. Reads that follow them go to data space.
- R6: After an index prefix (0xDD or 0xFD), some opcodes take one displacement byte, which is added to their operand count. These are 0x34, 0x35 and 0x36, opcodes 0x40 to 0x7F with exactly one of bits [5:3] and [2:0] equal to 110, and opcodes 0x80 to 0xBF with bits [2:0] equal to 110. As a result, 0xDD 0x36 has two program-space operand bytes.
- R7: After a plain bit prefix 0xCB, the next fetched byte ends the instruction and is not decoded as an opcode. For example, 0xCB 0x06 has no operand byte.
- R8: For an index prefix followed by 0xCB, the next non-fetch read (the displacement) goes to program space. The opcode fetch after it ends the instruction, and later reads go to data space.
- R9: Writes always give `prog_space`=0. A write in the middle of an operand count does not consume any of the count.
- R10: With `slow_prog`=1, `wait_req` is 1 for exactly one clock, starting one clock after an opcode-fetch read begins. With `slow_prog`=0, or on non-fetch reads, `wait_req` stays 0.
- R11: An operand read that is held active for several clocks consumes exactly one operand byte. The count steps when the read strobe ends.
- R12: When index prefixes repeat, the tracker stays indexed. For example, 0xDD 0xFD 0x21 has two program-space operand bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opfetch | input | 1 | Opcode-fetch status strobe, active high |
| mem_req | input | 1 | Memory request strobe, active high |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| bus_data | input | 8 | Data bus as seen during reads |
| slow_prog | input | 1 | Enables one wait clock per opcode fetch |
| prog_space | output | 1 | Extra address bit: 1 for program space, 0 for data space |
| wait_req | output | 1 | Wait request to the processor, active high |

## Verification
On every slow opcode fetch, the wait pulse and program-space steering are active in the same clock. The wait pulse starts from the same fetch that the tracker later decodes. The bench sweeps all opcodes with slow memory enabled and checks `prog_space` and `wait_req` on each clock of every fetch. It then repeats the indexed sweep with slow memory disabled and expects no wait pulse. Writes placed inside an operand count, and reads stretched over several clocks, test whether the count steps only once per read strobe end.

// File: rtl/opsep_pkg.sv
package opsep_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2;

    localparam logic [BYTE_W-1:0] OP_BIT_PFX = 8'hCB;
    localparam logic [BYTE_W-1:0] OP_IX_PFX  = 8'hDD;
    localparam logic [BYTE_W-1:0] OP_IY_PFX  = 8'hFD;

    typedef enum logic [2:0] {
        TRK_IDLE,
        TRK_INDEX,
        TRK_BITOP,
        TRK_OPERAND,
        TRK_XDISP,
        TRK_XOP
    } trk_state_t;

    typedef struct packed {
        logic             index_pfx;
        logic             bit_pfx;
        logic [CNT_W-1:0] nbytes;
    } op_info_t;

    // Operand byte count of one opcode; indexed adds a displacement byte
    // where the opcode refers to the memory operand.
    function automatic op_info_t decode_op(input logic [BYTE_W-1:0] op,
                                           input logic indexed);
        op_info_t   info;
        logic       imm1;
        logic       imm2;
        logic       memref;
        logic [1:0] grp;
        grp  = op[7:6];
        imm1 = ((grp == 2'b00) || (grp == 2'b11)) && (op[2:0] == 3'b110);
        imm2 = ((grp == 2'b00) && (op[3:0] == 4'b0001))
             || (op == 8'hC3) || (op == 8'hCD);
        memref = (op == 8'h34) || (op == 8'h35) || (op == 8'h36)
               || ((grp == 2'b01) && ((op[2:0] == 3'b110) ^ (op[5:3] == 3'b110)))
               || ((grp == 2'b10) && (op[2:0] == 3'b110));
        info.index_pfx = (op == OP_IX_PFX) || (op == OP_IY_PFX);
        info.bit_pfx   = (op == OP_BIT_PFX);
        info.nbytes    = CNT_W'(imm1) + CNT_W'({imm2, 1'b0})
                       + CNT_W'(indexed && memref);
        return info;
    endfunction

endpackage

// File: rtl/opsep_bus_classify.sv
module opsep_bus_classify
    import opsep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opfetch,
    input  logic              mem_req,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] bus_data,
    output logic              rd_act,
    output logic              fetch_act,
    output logic              fetch_start,
    output logic              rd_end,
    output logic              end_was_fetch,
    output logic [BYTE_W-1:0] byte_q
);

    logic rd_q;
    logic fetch_q;

    always_comb begin
        rd_act        = mem_req && rd_stb && !wr_stb;
        fetch_act     = rd_act && opfetch;
        fetch_start   = fetch_act && !fetch_q;
        rd_end        = rd_q && !rd_act;
        end_was_fetch = fetch_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            fetch_q <= 1'b0;
            byte_q  <= '0;
        end else begin
            rd_q    <= rd_act;
            fetch_q <= fetch_act;
            if (rd_act) begin
                byte_q <= bus_data;
            end
        end
    end

endmodule

// File: rtl/opsep_tracker.sv
module opsep_tracker
    import opsep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_end,
    input  logic              end_was_fetch,
    input  logic [BYTE_W-1:0] byte_q,
    output logic              prog_window
);

    trk_state_t       state;
    trk_state_t       state_n;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_n;
    op_info_t         info;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TRK_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        info    = decode_op(byte_q, state == TRK_INDEX);
        if (rd_end && end_was_fetch) begin
            unique case (state)
                TRK_BITOP, TRK_XOP: begin
                    state_n = TRK_IDLE;
                end
                default: begin
                    if (info.index_pfx) begin
                        state_n = TRK_INDEX;
                    end else if (info.bit_pfx) begin
                        state_n = (state == TRK_INDEX) ? TRK_XDISP : TRK_BITOP;
                    end else if (info.nbytes != '0) begin
                        state_n = TRK_OPERAND;
                        cnt_n   = info.nbytes;
                    end else begin
                        state_n = TRK_IDLE;
                    end
                end
            endcase
        end else if (rd_end) begin
            unique case (state)
                TRK_OPERAND: begin
                    if (cnt == CNT_W'(1)) begin
                        state_n = TRK_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt - CNT_W'(1);
                    end
                end
                TRK_XDISP: begin
                    state_n = TRK_XOP;
                end
                default: begin
                    state_n = state;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state)
            TRK_OPERAND, TRK_XDISP: prog_window = 1'b1;
            default:                prog_window = 1'b0;
        endcase
    end

endmodule

// File: rtl/opsep_wait_gen.sv
module opsep_wait_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_prog,
    input  logic fetch_start,
    output logic wait_req
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_req <= 1'b0;
        end else begin
            wait_req <= slow_prog && fetch_start;
        end
    end

endmodule

// File: rtl/opsep_top.sv
module opsep_top
    import opsep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opfetch,
    input  logic              mem_req,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] bus_data,
    input  logic              slow_prog,
    output logic              prog_space,
    output logic              wait_req
);

    logic              rd_act;
    logic              fetch_act;
    logic              fetch_start;
    logic              rd_end;
    logic              end_was_fetch;
    logic [BYTE_W-1:0] byte_q;
    logic              prog_window;

    opsep_bus_classify u_cls (
        .clk           (clk),
        .rst_n         (rst_n),
        .opfetch       (opfetch),
        .mem_req       (mem_req),
        .rd_stb        (rd_stb),
        .wr_stb        (wr_stb),
        .bus_data      (bus_data),
        .rd_act        (rd_act),
        .fetch_act     (fetch_act),
        .fetch_start   (fetch_start),
        .rd_end        (rd_end),
        .end_was_fetch (end_was_fetch),
        .byte_q        (byte_q)
    );

    opsep_tracker u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_end        (rd_end),
        .end_was_fetch (end_was_fetch),
        .byte_q        (byte_q),
        .prog_window   (prog_window)
    );

    opsep_wait_gen u_wait (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_prog   (slow_prog),
        .fetch_start (fetch_start),
        .wait_req    (wait_req)
    );

    assign prog_space = rd_act && (fetch_act || prog_window);

endmodule

// File: rtl/opsep_chk.sv
module opsep_chk (
    input logic clk,
    input logic rst_n,
    input logic opfetch,
    input logic mem_req,
    input logic rd_stb,
    input logic wr_stb,
    input logic slow_prog,
    input logic prog_space,
    input logic wait_req
);

    // R2: an opcode-fetch read always lands in program space
    a_r2_fetch_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && rd_stb && opfetch && !wr_stb) |-> prog_space);

    // R2: no memory read, no program-space bit
    a_r2_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> !prog_space);

    // R9: writes go to data space
    a_r9_write_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && wr_stb) |-> !prog_space);

    // R10: wait lasts a single clock
    a_r10_wait_single: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |=> !wait_req);

    // R10: wait only follows an enabled opcode fetch
    a_r10_wait_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> ($past(slow_prog) && $past(opfetch && mem_req && rd_stb)));

endmodule

bind opsep_top opsep_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opfetch    (opfetch),
    .mem_req    (mem_req),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .slow_prog  (slow_prog),
    .prog_space (prog_space),
    .wait_req   (wait_req)
);

// File: tb/tb_opsep_top.sv
module tb_opsep_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opfetch = 1'b0;
    logic       mem_req = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic       slow_prog = 1'b0;
    logic       prog_space;
    logic       wait_req;

    int checks = 0;
    int errs   = 0;

    localparam int K_FETCH = 0;
    localparam int K_READ  = 1;
    localparam int K_WRITE = 2;

    always #5 clk = ~clk;

    opsep_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .opfetch    (opfetch),
        .mem_req    (mem_req),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .bus_data   (bus_data),
        .slow_prog  (slow_prog),
        .prog_space (prog_space),
        .wait_req   (wait_req)
    );

    function automatic int imm_len(input logic [7:0] op);
        case (op)
            8'h06, 8'h0E, 8'h16, 8'h1E, 8'h26, 8'h2E, 8'h36, 8'h3E,
            8'hC6, 8'hCE, 8'hD6, 8'hDE, 8'hE6, 8'hEE, 8'hF6, 8'hFE: return 1;
            8'h01, 8'h11, 8'h21, 8'h31, 8'hC3, 8'hCD:               return 2;
            default:                                               return 0;
        endcase
    endfunction

    function automatic int disp_len(input logic [7:0] op);
        case (op)
            8'h34, 8'h35, 8'h36,
            8'h46, 8'h4E, 8'h56, 8'h5E, 8'h66, 8'h6E, 8'h7E,
            8'h70, 8'h71, 8'h72, 8'h73, 8'h74, 8'h75, 8'h77,
            8'h86, 8'h8E, 8'h96, 8'h9E, 8'hA6, 8'hAE, 8'hB6, 8'hBE: return 1;
            default:                                               return 0;
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s got %b exp %b", what, act, exp);
        end
    endtask

    // One bus cycle held for 'hold' clocks, then one idle clock.
    task automatic cyc(input int kind, input logic [7:0] d, input logic exp_p,
                       input int hold, input string tag);
        logic exp_w;
        @(negedge clk);
        mem_req  = 1'b1;
        opfetch  = (kind == K_FETCH);
        rd_stb   = (kind != K_WRITE);
        wr_stb   = (kind == K_WRITE);
        bus_data = d;
        #1;
        chk(prog_space, exp_p, {tag, " space at start"});
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            exp_w = (i == 0) && slow_prog && (kind == K_FETCH);
            chk(prog_space, exp_p, {tag, " space held"});
            chk(wait_req, exp_w, {tag, " R10 wait"});
        end
        @(negedge clk);
        mem_req = 1'b0;
        opfetch = 1'b0;
        rd_stb  = 1'b0;
        wr_stb  = 1'b0;
        #1;
        chk(prog_space, 1'b0, {tag, " R2 idle"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(wait_req, 1'b0, "R1 wait after reset");
        cyc(K_READ, 8'h3E, 1'b0, 3, "R1 read after reset");

        slow_prog = 1'b1;
        // R3 R4 R5 sweep of unprefixed opcodes
        for (int op = 0; op < 256; op++) begin
            if (op != 8'hCB && op != 8'hDD && op != 8'hFD) begin
                cyc(K_FETCH, 8'(op), 1'b1, 3, "R2 fetch");
                for (int k = 0; k < 3; k++) begin
                    cyc(K_READ, 8'h00, k < imm_len(8'(op)), 3, "R3 R4 R5 operand");
                end
            end
        end

        slow_prog = 1'b0;
        // R6 sweep of index-prefixed opcodes, no wait expected
        for (int op = 0; op < 256; op++) begin
            if (op != 8'hCB && op != 8'hDD && op != 8'hFD) begin
                cyc(K_FETCH, 8'hDD, 1'b1, 3, "R6 prefix");
                cyc(K_FETCH, 8'(op), 1'b1, 3, "R6 fetch");
                for (int k = 0; k < 4; k++) begin
                    cyc(K_READ, 8'h00, k < (imm_len(8'(op)) + disp_len(8'(op))),
                        3, "R6 indexed operand");
                end
            end
        end

        slow_prog = 1'b1;
        // R7: plain bit prefix
        cyc(K_FETCH, 8'hCB, 1'b1, 3, "R7 prefix");
        cyc(K_FETCH, 8'h06, 1'b1, 3, "R7 second");
        cyc(K_READ,  8'h00, 1'b0, 3, "R7 data read");

        // R8: indexed bit operation
        cyc(K_FETCH, 8'hFD, 1'b1, 3, "R8 prefix");
        cyc(K_FETCH, 8'hCB, 1'b1, 3, "R8 bit prefix");
        cyc(K_READ,  8'h05, 1'b1, 3, "R8 displacement");
        cyc(K_FETCH, 8'h46, 1'b1, 3, "R8 final");
        cyc(K_READ,  8'h00, 1'b0, 3, "R8 data read");

        // R9: write inside operand count
        cyc(K_FETCH, 8'h01, 1'b1, 3, "R9 fetch");
        cyc(K_WRITE, 8'h00, 1'b0, 3, "R9 write");
        cyc(K_READ,  8'h00, 1'b1, 3, "R9 operand 1");
        cyc(K_WRITE, 8'h00, 1'b0, 3, "R9 write");
        cyc(K_READ,  8'h00, 1'b1, 3, "R9 operand 2");
        cyc(K_READ,  8'h00, 1'b0, 3, "R9 data read");

        // R11: stretched operand read counts once
        cyc(K_FETCH, 8'hCD, 1'b1, 4, "R11 fetch");
        cyc(K_READ,  8'h00, 1'b1, 6, "R11 long operand");
        cyc(K_READ,  8'h00, 1'b1, 3, "R11 operand 2");
        cyc(K_READ,  8'h00, 1'b0, 3, "R11 data read");

        // R12: repeated prefixes
        cyc(K_FETCH, 8'hDD, 1'b1, 3, "R12 prefix 1");
        cyc(K_FETCH, 8'hFD, 1'b1, 3, "R12 prefix 2");
        cyc(K_FETCH, 8'h21, 1'b1, 3, "R12 fetch");
        cyc(K_READ,  8'h00, 1'b1, 3, "R12 operand 1");
        cyc(K_READ,  8'h00, 1'b1, 3, "R12 operand 2");
        cyc(K_READ,  8'h00, 1'b0, 3, "R12 data read");

        // R10: disabled slow memory
        slow_prog = 1'b0;
        cyc(K_FETCH, 8'h00, 1'b1, 3, "R10 no wait fetch");

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule